// File: doc/BRIEF.md
# UART Receive Path

This block is the serial receive side of one UART channel. It watches an asynchronous serial input and times every bit with a 16x baud-rate enable supplied from outside. When the line falls, the block times half a bit and then checks that the line is still low. If it is, the block collects 5 to 8 data bits, least significant bit first. An optional even or odd parity bit follows, then one or two stop bits. Each finished character is written into a 16-entry receive queue together with its own parity, framing and break flags.

The CPU side pops the head entry with a one-cycle read strobe. The block shows the head data, that entry's error flags, a data-ready indication and a sticky overrun flag. The configuration inputs are expected to stay steady while a character is on the line.

Top module: `uart_rx_path`

## Requirements
- R1: After reset, `line_ready`, `line_overrun`, all three head flags and `rd_data` are 0.
- R2: The start bit is checked about 8 ticks after the falling edge. If the line has gone high again by then, the edge is a false start: nothing is stored and the receiver waits for the next falling edge.
- R3: `wlen_sel` sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits are taken at mid-bit, least significant bit first. The character appears right-justified in `rd_data`, with the unused upper bits at 0.
- R4: When `par_en` is 1, a parity bit follows the data bits. `par_odd`=0 expects even parity and `par_odd`=1 expects odd parity. A mismatch sets the entry's parity flag. When `par_en` is 0, no parity bit is expected and the flag is 0.
- R5: `stop_two`=0 expects one stop bit and `stop_two`=1 expects two. A first stop bit sampled low sets the entry's framing flag.
- R6: The entry's break flag is set when every data bit, the parity bit (if enabled) and the first stop bit are all sampled low.
- R7: The queue holds 16 characters and returns them in arrival order. Each entry keeps its own flags. The head data stays steady until it is popped.
- R8: A character that completes while the queue holds 16 entries is dropped and sets `line_overrun`; the stored entries stay unchanged. `line_overrun` stays set until the next `rd_pop`, which clears it.
- R9: `rd_pop` removes the head entry. A pop while the queue is empty has no effect.
- R10: `line_ready` is 1 exactly when the queue is not empty. While it is 0, `rd_data` and the head flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| wlen_sel | input | 2 | Data length select (00=5 ... 11=8) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| stop_two | input | 1 | 1 = two stop bits |
| rd_pop | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head character, right-justified |
| line_ready | output | 1 | Queue not empty |
| line_overrun | output | 1 | Sticky overrun indication |
| head_parity_err | output | 1 | Parity flag of the head entry |
| head_frame_err | output | 1 | Framing flag of the head entry |
| head_break | output | 1 | Break flag of the head entry |

## Verification
The bench sends a low glitch shorter than half a bit; a receiver without the mid-start check would store a bogus character. It runs every word length with different parity and stop settings: a wrong bit order, a wrong length decode or an inverted parity sense would show up as a wrong right-justified value or a wrong parity flag. It fills the queue past 16 entries; a design that overwrote entries would return changed data, and one that never flagged the drop would leave `line_overrun` low. A bad-parity character sent just before a clean one shows whether each flag stays with its own character, and a pop on an empty queue must leave a later character intact.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;
endpackage

// File: rtl/uart_rx_bit_engine.sv
module uart_rx_bit_engine
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rx_s,
  input  logic [1:0] wlen_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stop_two,
  output logic       char_push,
  output rx_char_t   char_out
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_C  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

  rx_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bidx_q, bidx_d;
  logic [7:0]    sh_q, sh_d;
  logic          acc_q, acc_d, any_q, any_d, ferr_q, ferr_d;
  logic          prev_q, prev_d, push_q, push_d;
  rx_char_t      char_q, char_d;
  logic [2:0]    nlast;
  logic          fin, fin_ferr, fin_any, at_sample;

  assign nlast     = 3'd4 + {1'b0, wlen_sel};
  assign at_sample = (cnt_q == LAST_C);

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    bidx_d   = bidx_q;
    sh_d     = sh_q;
    acc_d    = acc_q;
    any_d    = any_q;
    ferr_d   = ferr_q;
    prev_d   = prev_q;
    push_d   = 1'b0;
    char_d   = char_q;
    fin      = 1'b0;
    fin_ferr = ferr_q;
    fin_any  = any_q;
    if (tick) begin
      prev_d = rx_s;
      case (state_q)
        ST_IDLE: if (prev_q && !rx_s) begin
          state_d = ST_START;
          cnt_d   = '0;
        end
        ST_START: if (cnt_q == MID_C) begin
          cnt_d  = '0;
          bidx_d = '0;
          acc_d  = 1'b0;
          any_d  = 1'b0;
          state_d = rx_s ? ST_IDLE : ST_DATA;
        end else cnt_d = cnt_q + 1'b1;
        ST_DATA: if (at_sample) begin
          cnt_d = '0;
          sh_d  = {rx_s, sh_q[7:1]};
          acc_d = acc_q ^ rx_s;
          any_d = any_q | rx_s;
          if (bidx_q == nlast) state_d = par_en ? ST_PAR : ST_STOP1;
          else bidx_d = bidx_q + 1'b1;
        end else cnt_d = cnt_q + 1'b1;
        ST_PAR: if (at_sample) begin
          cnt_d   = '0;
          acc_d   = acc_q ^ rx_s;
          any_d   = any_q | rx_s;
          state_d = ST_STOP1;
        end else cnt_d = cnt_q + 1'b1;
        ST_STOP1: if (at_sample) begin
          cnt_d    = '0;
          ferr_d   = !rx_s;
          any_d    = any_q | rx_s;
          fin_ferr = !rx_s;
          fin_any  = any_q | rx_s;
          if (stop_two) state_d = ST_STOP2;
          else fin = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
        ST_STOP2: if (at_sample) fin = 1'b1;
                  else cnt_d = cnt_q + 1'b1;
        default: state_d = ST_IDLE;
      endcase
      if (fin) begin
        state_d     = ST_IDLE;
        cnt_d       = '0;
        push_d      = 1'b1;
        char_d.data = sh_q >> (3'd7 - nlast);
        char_d.perr = par_en & (acc_q ^ par_odd);
        char_d.ferr = fin_ferr;
        char_d.brk  = !fin_any;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      acc_q   <= 1'b0;
      any_q   <= 1'b0;
      ferr_q  <= 1'b0;
      prev_q  <= 1'b1;
      push_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bidx_q  <= bidx_d;
      sh_q    <= sh_d;
      acc_q   <= acc_d;
      any_q   <= any_d;
      ferr_q  <= ferr_d;
      prev_q  <= prev_d;
      push_q  <= push_d;
      char_q  <= char_d;
    end
  end

  assign char_push = push_q;
  assign char_out  = char_q;
endmodule

// File: rtl/uart_rx_char_fifo.sv
module uart_rx_char_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  rx_char_t din,
  input  logic     pop,
  output rx_char_t dout,
  output logic     empty,
  output logic     full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_C = (AW + 1)'(DEPTH);

  rx_char_t    mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_wr, do_rd;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == DEPTH_C);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;

  always_comb begin
    wp_d  = do_wr ? wp_q + 1'b1 : wp_q;
    rp_d  = do_rd ? rp_q + 1'b1 : rp_q;
    cnt_d = cnt_q + {{AW{1'b0}}, do_wr} - {{AW{1'b0}}, do_rd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= din;
  end

  assign dout = mem[rp_q];
endmodule

// File: rtl/uart_rx_path.sv
module uart_rx_path
  import uart_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_line,
  input  logic [1:0] wlen_sel,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stop_two,
  input  logic       rd_pop,
  output logic [7:0] rd_data,
  output logic       line_ready,
  output logic       line_overrun,
  output logic       head_parity_err,
  output logic       head_frame_err,
  output logic       head_break
);
  logic [1:0] rst_sync_q, rx_sync_q;
  logic       rst_s, ovr_q, ovr_d;
  logic       char_push, fifo_empty, fifo_full;
  rx_char_t   char_new, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rx_sync_q <= 2'b11;
    else        rx_sync_q <= {rx_sync_q[0], rx_line};
  end

  uart_rx_bit_engine #(.OSR(OSR)) u_engine (
    .clk(clk), .rst_n(rst_s), .tick(tick16), .rx_s(rx_sync_q[1]),
    .wlen_sel(wlen_sel), .par_en(par_en), .par_odd(par_odd),
    .stop_two(stop_two), .char_push(char_push), .char_out(char_new)
  );

  uart_rx_char_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_s), .push(char_push), .din(char_new),
    .pop(rd_pop), .dout(head), .empty(fifo_empty), .full(fifo_full)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (char_push && fifo_full) ovr_d = 1'b1;
    else if (rd_pop)            ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end

  assign line_ready      = !fifo_empty;
  assign line_overrun    = ovr_q;
  assign rd_data         = fifo_empty ? 8'h00 : head.data;
  assign head_parity_err = !fifo_empty && head.perr;
  assign head_frame_err  = !fifo_empty && head.ferr;
  assign head_break      = !fifo_empty && head.brk;
endmodule

// File: rtl/uart_rx_path_check.sv
module uart_rx_path_check (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_pop,
  input logic       char_push,
  input logic       fifo_full,
  input logic [7:0] rd_data,
  input logic       line_ready,
  input logic       line_overrun,
  input logic       head_parity_err,
  input logic       head_frame_err,
  input logic       head_break
);
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !line_ready |-> (rd_data == 8'h00 && !head_parity_err && !head_frame_err && !head_break)); // R10
  AST_PUSH_MAKES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    char_push && !fifo_full |=> line_ready); // R10
  AST_FULL_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    char_push && fifo_full |=> line_overrun); // R8
  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    line_overrun && !rd_pop |=> line_overrun); // R8
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    line_ready && !rd_pop |=> line_ready && $stable(rd_data)); // R7
  AST_EMPTY_POP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !line_ready && !char_push |=> !line_ready); // R9
endmodule

bind uart_rx_path uart_rx_path_check u_check (
  .clk(clk), .rst_n(rst_n), .rd_pop(rd_pop), .char_push(char_push),
  .fifo_full(fifo_full), .rd_data(rd_data), .line_ready(line_ready),
  .line_overrun(line_overrun), .head_parity_err(head_parity_err),
  .head_frame_err(head_frame_err), .head_break(head_break)
);

// File: tb/uart_rx_path_test.sv
module uart_rx_path_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] wlen_sel = 2'd3;
  logic       par_en = 1'b0, par_odd = 1'b0, stop_two = 1'b0, rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic       line_ready, line_overrun, head_parity_err, head_frame_err, head_break;
  logic [1:0] tdiv = 2'd0;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  uart_rx_path uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_line(rx_line),
    .wlen_sel(wlen_sel), .par_en(par_en), .par_odd(par_odd), .stop_two(stop_two),
    .rd_pop(rd_pop), .rd_data(rd_data), .line_ready(line_ready),
    .line_overrun(line_overrun), .head_parity_err(head_parity_err),
    .head_frame_err(head_frame_err), .head_break(head_break)
  );

  always #4 clk = ~clk;
  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  typedef struct packed {
    logic [1:0] wl; logic pe; logic po; logic two; logic stoplo; logic badpar;
    logic [7:0] data; logic epe; logic efe; logic ebrk;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0, 1'b0},
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h13, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h5C, 1'b1, 1'b0, 1'b0},
    '{2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h2A, 1'b0, 1'b0, 1'b0},
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
    '{2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0, 1'b0},
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic lvl);
    rx_line = lvl;
    repeat (64) @(negedge clk);
  endtask

  task automatic send_frame(input int nb, input logic [7:0] d, input logic pe,
                            input logic pbit, input logic stop_lvl, input logic two);
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) hold_bit(d[i]);
    if (pe) hold_bit(pbit);
    hold_bit(stop_lvl);
    if (two) hold_bit(1'b1);
    hold_bit(1'b1);
    hold_bit(1'b1);
  endtask

  task automatic pop_one();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic plain_cfg();
    wlen_sel = 2'd3; par_en = 1'b0; par_odd = 1'b0; stop_two = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 ready", line_ready, 0);
    check("R1 overrun", line_overrun, 0);
    check("R1 flags", {head_parity_err, head_frame_err, head_break}, 0);
    check("R1 data", rd_data, 0);

    // table walk: R3 length, R4 parity, R5 stop, R6 break
    for (int v = 0; v < 8; v++) begin
      int nb;
      logic [7:0] mask, exp_d;
      logic pbit;
      wlen_sel = VEC[v].wl; par_en = VEC[v].pe; par_odd = VEC[v].po; stop_two = VEC[v].two;
      nb    = 5 + int'(VEC[v].wl);
      mask  = 8'((16'd1 << nb) - 16'd1);
      exp_d = VEC[v].data & mask;
      pbit  = (^exp_d) ^ VEC[v].po ^ VEC[v].badpar;
      send_frame(nb, VEC[v].data, VEC[v].pe, pbit, !VEC[v].stoplo, VEC[v].two);
      check("R10 ready after char", line_ready, 1);
      check("R3 data", rd_data, exp_d);
      check("R4 parity flag", head_parity_err, VEC[v].epe);
      check("R5 framing flag", head_frame_err, VEC[v].efe);
      check("R6 break flag", head_break, VEC[v].ebrk);
      pop_one();
      check("R9 popped", line_ready, 0);
    end

    // R2 false start: low for a quarter bit only
    plain_cfg();
    rx_line = 1'b0;
    repeat (16) @(negedge clk);
    hold_bit(1'b1); hold_bit(1'b1); hold_bit(1'b1);
    check("R2 nothing stored", line_ready, 0);
    send_frame(8, 8'h6E, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R2 next char ok", rd_data, 8'h6E);
    pop_one();

    // R9 pop on empty has no effect
    pop_one();
    check("R9 empty pop ready", line_ready, 0);
    check("R9 empty pop overrun", line_overrun, 0);
    send_frame(8, 8'hC3, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R9 char after empty pop", rd_data, 8'hC3);
    pop_one();
    check("R9 queue empty again", line_ready, 0);

    // R7 flags travel with their own character
    wlen_sel = 2'd3; par_en = 1'b1; par_odd = 1'b0;
    send_frame(8, 8'h07, 1'b1, 1'b0, 1'b1, 1'b0);
    send_frame(8, 8'h03, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R7 first flag", head_parity_err, 1);
    check("R7 first data", rd_data, 8'h07);
    pop_one();
    check("R7 second flag", head_parity_err, 0);
    check("R7 second data", rd_data, 8'h03);
    pop_one();

    // R8 overrun: 17 characters with no pop
    plain_cfg();
    for (int k = 0; k < 17; k++) send_frame(8, 8'(8'h10 + k), 1'b0, 1'b0, 1'b1, 1'b0);
    check("R8 overrun set", line_overrun, 1);
    check("R8 head kept", rd_data, 8'h10);
    for (int k = 0; k < 16; k++) begin
      check("R7 order", rd_data, 8'h10 + k);
      pop_one();
      if (k == 0) check("R8 overrun cleared by pop", line_overrun, 0);
    end
    check("R7 depth 16", line_ready, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule